// File: doc/BRIEF.md
# Moving-Average Baseline Spike Detector

This block watches a stream of ADC codes that arrive with a valid strobe, one code per strobe and never stalled. It keeps a running mean of the last 32 accepted codes as a baseline. A sample is a spike when it sits above that baseline by more than a programmable threshold. The baseline used for this test is the one from before the sample joins the window, so a large sample cannot raise its own reference. Every such sample raises its own one-cycle spike pulse. The current baseline is also driven out, so a framer or logger can record it next to the raw code.

Samples are unsigned by default. A parameter switches the block to two's-complement input. Internally, signed codes are turned into an offset code by flipping the top bit, so a single unsigned datapath serves both variants. A small state machine gates the spike output. It stays in `ST_FILL` from reset until 32 samples have been accepted, then takes the transition `FILL_TO_ARMED` into `ST_ARMED`. It remains in `ST_ARMED` until the next reset, and that reset is the transition `ANY_TO_FILL`.

Top module: `spike_baseline_detector`

## Requirements
- R1: While reset is held and right after it is released, `spike_o` is 0 and `baseline_o` reads zero (0 for unsigned codes, and signed zero in signed mode).
- R2: A sample accepted at a clock edge with `smp_valid_i` high is a spike when it is strictly greater than (baseline before that edge + `thr_code_i`), with no wrap-around in the sum. `spike_o` is high for the single cycle after that edge. A sample exactly equal to baseline + threshold is not a spike.
- R3: The comparison uses the baseline that excludes the current sample. After the edge, `baseline_o` equals floor(sum of the last 32 accepted samples / 32). Window slots that have not been filled since reset count as zero.
- R4: Each sample that exceeds the threshold gives its own pulse. Samples accepted on consecutive cycles that all exceed give `spike_o` high on consecutive cycles, and the pulses are not merged.
- R5: `spike_o` stays 0 for the first 32 samples after reset, whatever their values. The 33rd sample is the first that can be flagged.
- R6: A cycle with `smp_valid_i` low changes nothing. `spike_o` is 0 in the next cycle, `baseline_o` keeps its value, and the data and threshold inputs are ignored.
- R7: A new sample is accepted on every cycle that `smp_valid_i` is high, with no stall and no lost sample, including back-to-back strobes.
- R8: With `SIGNED_MODE`=1, the codes `smp_data_i` and `baseline_o` are two's complement. The baseline is the floor of the signed mean, and the threshold stays an unsigned magnitude.
- R9: The threshold is taken on the same edge as each sample. A change of `thr_code_i` applies to the very sample that arrives with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | A sample is present this cycle |
| smp_data_i | input | W (12) | ADC code, unsigned or two's complement |
| thr_code_i | input | W (12) | Unsigned spike threshold above baseline, in codes |
| spike_o | output | 1 | One-cycle pulse per spiking sample |
| baseline_o | output | W (12) | Current moving-average baseline |

## Verification
Both results of a sample are due one clock after the edge that accepts it. `spike_o` carries the verdict for that sample, and `baseline_o` already includes it. After an idle cycle both must look exactly as they did before. The bench updates its queue-based model at the accepting edge and compares both outputs at the following falling edge, for an unsigned and a signed instance on every cycle. The directed checks sample at that same point, after the task that presented the sample has returned.

// File: rtl/spk_pkg.sv
package spk_pkg;

    // Fill tracking of the averaging window
    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,   // fewer than a full window of samples since reset
        ST_ARMED = 1'b1    // window full, spike decisions allowed
    } fill_state_t;

endpackage

// File: rtl/spk_delay_line.sv
// Circular delay line: exposes the sample that leaves the window on the next push.
module spk_delay_line #(
    parameter int              W          = 12,
    parameter int              DEPTH_LOG2 = 5,
    parameter logic [W-1:0]    INIT       = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] oldest_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [W-1:0]          slot_q [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= INIT;
            end
        end else if (push_i) begin
            slot_q[wr_ptr_q] <= din_i;
            wr_ptr_q         <= wr_ptr_q + 1'b1;
        end
    end

    // The slot about to be overwritten holds the sample from DEPTH pushes ago
    assign oldest_o = slot_q[wr_ptr_q];

endmodule

// File: rtl/spk_running_sum.sv
// Running window sum: adds the entering sample, drops the leaving one.
module spk_running_sum #(
    parameter int                       W        = 12,
    parameter int                       WIN_LOG2 = 5,
    parameter logic [W+WIN_LOG2-1:0]    INIT_SUM = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_i,
    input  logic [W-1:0] new_i,
    input  logic [W-1:0] old_i,
    output logic [W-1:0] mean_o
);
    localparam int SUM_W = W + WIN_LOG2;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;

    always_comb begin
        sum_next = sum_q + SUM_W'(new_i) - SUM_W'(old_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= INIT_SUM;
        end else if (add_i) begin
            sum_q <= sum_next;
        end
    end

    // Division by the window size is a plain slice
    assign mean_o = sum_q[SUM_W-1:WIN_LOG2];

endmodule

// File: rtl/spk_fill_fsm.sv
// Tracks whether a full window has been received since reset.
module spk_fill_fsm
    import spk_pkg::*;
#(
    parameter int WIN_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic armed_o
);
    localparam logic [WIN_LOG2-1:0] LAST_FILL = '1;

    fill_state_t         state_q, state_d;
    logic [WIN_LOG2-1:0] fill_cnt_q, fill_cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_FILL;     // ANY_TO_FILL
            fill_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            fill_cnt_q <= fill_cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        fill_cnt_d = fill_cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (adv_i) begin
                    fill_cnt_d = fill_cnt_q + 1'b1;
                    if (fill_cnt_q == LAST_FILL) begin
                        state_d = ST_ARMED;   // FILL_TO_ARMED
                    end
                end
            end
            ST_ARMED: begin
                state_d = ST_ARMED;
            end
            default: begin
                state_d = ST_FILL;
            end
        endcase
    end

    // Outputs
    always_comb begin
        armed_o = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/spike_baseline_detector.sv
// Moving-average baseline with threshold spike flag.
module spike_baseline_detector #(
    parameter int W           = 12,
    parameter int WIN_LOG2    = 5,
    parameter bit SIGNED_MODE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid_i,
    input  logic [W-1:0] smp_data_i,
    input  logic [W-1:0] thr_code_i,
    output logic         spike_o,
    output logic [W-1:0] baseline_o
);
    localparam int SUM_W = W + WIN_LOG2;

    // Offset-code mask: signed input gets its top bit flipped
    localparam logic [W-1:0] BIAS_MASK =
        SIGNED_MODE ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};
    localparam logic [SUM_W-1:0] SUM_INIT =
        {{WIN_LOG2{1'b0}}, BIAS_MASK} << WIN_LOG2;

    logic [W-1:0] smp_ofs;
    logic [W-1:0] oldest_ofs;
    logic [W-1:0] mean_ofs;
    logic         armed;
    logic         exceed;
    logic         spike_q;

    assign smp_ofs = smp_data_i ^ BIAS_MASK;

    spk_delay_line #(
        .W          (W),
        .DEPTH_LOG2 (WIN_LOG2),
        .INIT       (BIAS_MASK)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (smp_valid_i),
        .din_i    (smp_ofs),
        .oldest_o (oldest_ofs)
    );

    spk_running_sum #(
        .W        (W),
        .WIN_LOG2 (WIN_LOG2),
        .INIT_SUM (SUM_INIT)
    ) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (smp_valid_i),
        .new_i  (smp_ofs),
        .old_i  (oldest_ofs),
        .mean_o (mean_ofs)
    );

    spk_fill_fsm #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (smp_valid_i),
        .armed_o (armed)
    );

    // mean_ofs is still the pre-sample baseline during the accepting cycle
    always_comb begin
        exceed = {1'b0, smp_ofs} > ({1'b0, mean_ofs} + {1'b0, thr_code_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spike_q <= 1'b0;
        end else begin
            spike_q <= smp_valid_i & armed & exceed;
        end
    end

    assign spike_o    = spike_q;
    assign baseline_o = mean_ofs ^ BIAS_MASK;

endmodule

// File: rtl/spk_checker.sv
// Port-level properties of the spike detector.
module spk_checker #(
    parameter int W           = 12,
    parameter int WIN_LOG2    = 5,
    parameter bit SIGNED_MODE = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_valid_i,
    input logic [W-1:0] smp_data_i,
    input logic [W-1:0] thr_code_i,
    input logic         spike_o,
    input logic [W-1:0] baseline_o
);
    localparam int CNT_W = WIN_LOG2 + 2;
    localparam logic [CNT_W-1:0] WIN_C   = CNT_W'(1 << WIN_LOG2);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'((1 << WIN_LOG2) + 1);
    localparam logic [W-1:0]     MASK    =
        SIGNED_MODE ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};

    logic [CNT_W-1:0] seen_q;
    logic [W:0]       lhs, rhs;
    logic             above;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (smp_valid_i && seen_q != SAT_C) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    always_comb begin
        lhs   = {1'b0, smp_data_i ^ MASK};
        rhs   = {1'b0, baseline_o ^ MASK} + {1'b0, thr_code_i};
        above = lhs > rhs;
    end

    // R2: a pulse only follows an accepted sample that exceeded
    a_r2_flag_needs_excess: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> ($past(smp_valid_i) && $past(above)));

    // R2/R4: every exceeding sample after the fill gets its pulse
    a_r4_each_excess_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_valid_i) && $past(above) && $past(seen_q) >= WIN_C) |-> spike_o);

    // R5: no pulse for the first window of samples
    a_r5_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
        spike_o |-> (seen_q > WIN_C));

    // R6: an idle cycle changes nothing
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid_i) |-> (!spike_o && $stable(baseline_o)));

endmodule

bind spike_baseline_detector spk_checker #(
    .W           (W),
    .WIN_LOG2    (WIN_LOG2),
    .SIGNED_MODE (SIGNED_MODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .thr_code_i  (thr_code_i),
    .spike_o     (spike_o),
    .baseline_o  (baseline_o)
);

// File: tb/spike_baseline_detector_tb.sv
module spike_baseline_detector_tb;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] thr = '0;
    logic         spk_u, spk_s;
    logic [W-1:0] base_u, base_s;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    spike_baseline_detector #(.W(W), .WIN_LOG2(5), .SIGNED_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .smp_data_i(data),
        .thr_code_i(thr), .spike_o(spk_u), .baseline_o(base_u));

    spike_baseline_detector #(.W(W), .WIN_LOG2(5), .SIGNED_MODE(1'b1)) u_dut_sgn (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .smp_data_i(data),
        .thr_code_i(thr), .spike_o(spk_s), .baseline_o(base_s));

    // ---------------- reference model ----------------
    int win_u[$];
    int win_s[$];
    int sum_u, sum_s, seen;
    int exp_spk_u, exp_spk_s, exp_base_u, exp_base_s;

    task automatic model_reset();
        win_u = {}; win_s = {};
        for (int i = 0; i < 32; i++) begin
            win_u.push_back(0);
            win_s.push_back(0);
        end
        sum_u = 0; sum_s = 0; seen = 0;
        exp_spk_u = 0; exp_spk_s = 0; exp_base_u = 0; exp_base_s = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            exp_spk_u = 0;
            exp_spk_s = 0;
            if (valid) begin
                int du, ds, t;
                du = int'(data);
                ds = int'($signed(data));
                t  = int'(thr);
                exp_spk_u = (seen >= 32 && du > (sum_u >>> 5) + t) ? 1 : 0;
                exp_spk_s = (seen >= 32 && ds > (sum_s >>> 5) + t) ? 1 : 0;
                sum_u = sum_u + du - win_u.pop_front();
                sum_s = sum_s + ds - win_s.pop_front();
                win_u.push_back(du);
                win_s.push_back(ds);
                if (seen < 40) seen++;
                exp_base_u = sum_u >>> 5;
                exp_base_s = sum_s >>> 5;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(spk_u) == exp_spk_u, cur_req, "unsigned spike", int'(spk_u), exp_spk_u);
            check(int'(base_u) == exp_base_u, cur_req, "unsigned baseline", int'(base_u), exp_base_u);
            check(int'(spk_s) == exp_spk_s, cur_req, "signed spike", int'(spk_s), exp_spk_s);
            check(int'($signed(base_s)) == exp_base_s, cur_req, "signed baseline",
                  int'($signed(base_s)), exp_base_s);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int d, input int t);
        valid = 1'b1;
        data  = W'(d);
        thr   = W'(t);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic idle(input int n);
        valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            data = W'(i * 977);
            thr  = W'(i * 13);
            @(negedge clk);
        end
    endtask

    task automatic flush(input int d);
        for (int i = 0; i < 32; i++) send(d, 4095);
    endtask

    int flags;
    logic [15:0] lfsr;

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check(spk_u == 1'b0, "R1", "spike in reset", int'(spk_u), 0);
        check(base_u == '0, "R1", "baseline in reset", int'(base_u), 0);
        check(base_s == '0, "R1", "signed baseline in reset", int'(base_s), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(spk_u == 1'b0 && base_u == '0, "R1", "after release", int'(base_u), 0);

        // R5: fill with one large sample inside, no pulses
        cur_req = "R5";
        flags = 0;
        for (int i = 0; i < 32; i++) begin
            send((i == 10) ? 4000 : 1000, 100);
            flags += int'(spk_u);
        end
        check(flags == 0, "R5", "pulses during fill", flags, 0);
        check(int'(base_u) == 1093, "R5", "baseline after fill", int'(base_u), 1093);
        send(4000, 100);
        check(spk_u == 1'b1, "R5", "33rd sample flagged", int'(spk_u), 1);

        // R2: strict comparison boundary
        cur_req = "R2";
        flush(1000);
        send(1200, 200);
        check(spk_u == 1'b0, "R2", "equal to baseline+thr", int'(spk_u), 0);
        send(1207, 200);
        check(spk_u == 1'b1, "R2", "one above baseline+thr", int'(spk_u), 1);

        // R3: pre-sample baseline, then baseline includes the sample
        cur_req = "R3";
        flush(1000);
        send(2000, 980);
        check(spk_u == 1'b1, "R3", "compared to pre-sample baseline", int'(spk_u), 1);
        check(int'(base_u) == 1031, "R3", "baseline includes sample", int'(base_u), 1031);

        // R4 and R7: back-to-back spikes each flagged
        cur_req = "R4";
        flush(1000);
        flags = 0;
        valid = 1'b1; data = W'(3000); thr = W'(200);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            flags += int'(spk_u);
        end
        valid = 1'b0;
        check(flags == 5, "R4", "consecutive pulses", flags, 5);
        check(int'(base_u) == 1312, "R7", "every strobe accepted", int'(base_u), 1312);

        // R6: idle cycles with moving inputs
        cur_req = "R6";
        idle(6);
        check(spk_u == 1'b0 && int'(base_u) == 1312, "R6", "idle keeps baseline",
              int'(base_u), 1312);

        // R9: threshold follows each sample
        cur_req = "R9";
        flush(1000);
        send(1500, 600);
        check(spk_u == 1'b0, "R9", "high threshold", int'(spk_u), 0);
        send(1500, 400);
        check(spk_u == 1'b1, "R9", "lowered threshold on same sample", int'(spk_u), 1);

        // R8: signed codes
        cur_req = "R8";
        flush(-1000);
        check(int'($signed(base_s)) == -1000, "R8", "signed baseline", int'($signed(base_s)), -1000);
        send(-500, 300);
        check(spk_s == 1'b1, "R8", "signed spike", int'(spk_s), 1);
        send(-800, 300);
        check(spk_s == 1'b0, "R8", "signed no spike", int'(spk_s), 0);

        // R2 extremes: full-scale with zero threshold
        cur_req = "R2";
        flush(4094);
        send(4095, 0);
        check(spk_u == 1'b1, "R2", "full-scale above", int'(spk_u), 1);

        // R7: pseudo-random traffic, model compared every cycle
        cur_req = "R7";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            valid = lfsr[0] | lfsr[1];
            data  = lfsr[11:0];
            thr   = {3'b000, lfsr[15:7]};
            @(negedge clk);
        end
        valid = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule